// File: doc/BRIEF.md
# Cross-Parity Guarded Register File

This block is a small register file, by default eight registers of eight bits, that watches itself for soft errors. Alongside the data it holds three groups of stored check bits: one per register (row), one per bit position (column), and one per wrapped diagonal of the register-by-bit matrix. Diagonal `d` gathers every bit whose register index plus bit index, taken modulo N, equals `d`. N is both the register count and the data width.

A write does not recompute the check bits from scratch. It folds the difference between the old and the new row contents into the row, column and diagonal bits. On every cycle the three groups are also recomputed from the live contents and compared with the stored copies. The result is a set of mismatch vectors, a summary error flag and a classification. Exactly one mismatching row, one mismatching column and the diagonal that joins them form a single-bit upset, and the block reports its row and column. Any other non-zero pattern is reported as uncorrectable.

A correction strobe repairs a located single-bit upset in place. A separate upset-injection input flips one stored data bit without touching the check bits. It models a radiation hit so the checker can be exercised at the ports.

Top module: `xp_regfile_guard`

## Requirements
- R1: Synchronous active-low reset clears every register and every check bit. After reset every row reads 0 and `err`, `correctable` and `uncorrectable` are 0.
- R2: `rd_data` shows the register selected by `rd_addr` in the same cycle. A write lands at the clock edge and is readable in the next cycle.
- R3: When only writes and reads take place, with no injected upset, all mismatch vectors stay zero and `err` stays 0.
- R4: One cycle after a single bit (r, c) is flipped in a clean file, the following hold:
  - `row_mm` has only bit r set.
  - `col_mm` has only bit c set.
  - `diag_mm` has only bit (r+c) mod N set.
  - `correctable` is 1, `err_row`=r and `err_col`=c.
- R5: A mismatch pattern that is not exactly one row, one column and their joining diagonal sets `uncorrectable`=1 and `correctable`=0. Two flipped bits in one row are one example. Two bits on different rows, columns and diagonals are another.
- R6: `corr_en` while `correctable`=1 inverts bit (`err_row`, `err_col`) at the clock edge, and in the next cycle `err` is 0. This holds even when a write to another row occurs in the same cycle.
- R7: `corr_en` while the pattern is uncorrectable changes no register contents.
- R8: A write to the row that holds a located single-bit upset computes its difference against the repaired old value. After that write `err` is 0, whether or not `corr_en` was also asserted. If both are asserted in that cycle, the written data wins.
- R9: `err` is the OR of all mismatch bits. `correctable` and `uncorrectable` are never both 1, and one of them is 1 whenever `err` is 1.
- R10: `err_row` and `err_col` are 0 whenever `correctable` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register written |
| wr_data | input | N | Data written |
| rd_addr | input | AW | Register read |
| rd_data | output | N | Contents of the register at `rd_addr` |
| corr_en | input | 1 | Repair the located single-bit upset |
| flip_en | input | 1 | Upset injection: invert one stored bit, check bits untouched |
| flip_row | input | AW | Register of the injected upset |
| flip_col | input | AW | Bit position of the injected upset |
| err | output | 1 | Any check-bit mismatch |
| correctable | output | 1 | Mismatch pattern locates exactly one bit |
| uncorrectable | output | 1 | Mismatch present but not a single locatable bit |
| row_mm | output | N | Row parity mismatch vector |
| col_mm | output | N | Column parity mismatch vector |
| diag_mm | output | N | Diagonal parity mismatch vector, bit d = diagonal d |
| err_row | output | AW | Row of the located bit, 0 if none |
| err_col | output | AW | Column of the located bit, 0 if none |

## Verification
The write path and the repair path can act in the same cycle. They may touch different rows, or the very row that holds the located upset. In the second case the write difference must be taken against the repaired value, or the column and diagonal bits go stale.

The bench provokes both cases:
- It injects a single upset and then issues a write and `corr_en` together, once to another row and once to the faulty row.
- It repeats the faulty-row write without `corr_en`.

A behavioural model tracks two things separately: the contents the check bits describe and the actual contents. Every output is compared with that model on every cycle, so a wrong ordering shows up as a residual mismatch vector or as a wrong read value in the following cycle.

// File: rtl/xp_pkg.sv
// Shared types for the cross-parity register file guard.
// Assumes nothing beyond being compiled before the other modules.
package xp_pkg;
    // Classification of the current mismatch pattern.
    typedef enum logic [1:0] {
        XP_CLEAN  = 2'd0,
        XP_SINGLE = 2'd1,
        XP_MULTI  = 2'd2
    } xp_class_e;
endpackage

// File: rtl/xp_store.sv
// Data storage of the guarded register file.
// Per-row next value, in this order:
//   - a repair flip of the located bit;
//   - a write replaces the row (it wins over the repair);
//   - an injected upset inverts one bit on top.
// Assumes the repair request is already qualified by the classifier.
module xp_store #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [N-1:0]          wr_data,
    input  logic                  fix_en,
    input  logic [AW-1:0]         fix_row,
    input  logic [AW-1:0]         fix_col,
    input  logic                  flip_en,
    input  logic [AW-1:0]         flip_row,
    input  logic [AW-1:0]         flip_col,
    output logic [N-1:0][N-1:0]   mem
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0][N-1:0] mem_nxt;
    logic [N-1:0]        fix_mask;
    logic [N-1:0]        flip_mask;

    // Single-bit masks for repair and injection.
    always_comb begin
        fix_mask  = ONE << fix_col;
        flip_mask = ONE << flip_col;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        // Next contents of row r from repair, write and injection.
        always_comb begin
            mem_nxt[r] = mem[r];
            if (fix_en && fix_row == AW'(r))
                mem_nxt[r] = mem_nxt[r] ^ fix_mask;
            if (wr_en && wr_addr == AW'(r))
                mem_nxt[r] = wr_data;
            if (flip_en && flip_row == AW'(r))
                mem_nxt[r] = mem_nxt[r] ^ flip_mask;
        end
    end

    // Register the whole array.
    always_ff @(posedge clk) begin
        if (!rst_n) mem <= '0;
        else        mem <= mem_nxt;
    end

    // R6: a repair not overridden by a write or a same-bit injection inverts the bit.
    assert_fix_flips_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_en && !(wr_en && wr_addr == fix_row)
                && !(flip_en && flip_row == fix_row && flip_col == fix_col))
        |=> (mem[$past(fix_row)][$past(fix_col)] != $past(mem[fix_row][fix_col])))
        else $error("repair did not invert the located bit");
endmodule

// File: rtl/xp_parity.sv
// Stored check bits: row, column and wrapped diagonal parity.
// Each write folds delta = new ^ old into all three groups incrementally.
// Assumes old_row is the repaired previous contents of the written row.
module xp_parity #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [N-1:0]    wr_data,
    input  logic [N-1:0]    old_row,
    output logic [N-1:0]    row_p,
    output logic [N-1:0]    col_p,
    output logic [N-1:0]    diag_p
);
    logic [N-1:0]          delta;
    logic [N-1:0]          diag_delta;
    logic [N-1:0][N-1:0]   diag_terms;

    // Difference between the written and the previous row.
    always_comb delta = wr_data ^ old_row;

    // Bit c of row wr_addr lies on diagonal (wr_addr + c) mod N.
    for (genvar d = 0; d < N; d++) begin : g_diag
        for (genvar c = 0; c < N; c++) begin : g_bit
            assign diag_terms[d][c] = delta[c] & (wr_addr == AW'((d - c + N) % N));
        end
        assign diag_delta[d] = ^diag_terms[d];
    end

    // Update the three check groups on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_p  <= '0;
            col_p  <= '0;
            diag_p <= '0;
        end else if (wr_en) begin
            row_p[wr_addr] <= row_p[wr_addr] ^ (^delta);
            col_p          <= col_p ^ delta;
            diag_p         <= diag_p ^ diag_delta;
        end
    end
endmodule

// File: rtl/xp_locate.sv
// Live parity recomputation, mismatch vectors and upset classification.
// A single upset is exactly one row, one column and diagonal (row+col) mod N.
// Assumes N registers of N bits; purely combinational.
module xp_locate
    import xp_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0][N-1:0]   mem,
    input  logic [N-1:0]          row_p,
    input  logic [N-1:0]          col_p,
    input  logic [N-1:0]          diag_p,
    output logic [N-1:0]          row_mm,
    output logic [N-1:0]          col_mm,
    output logic [N-1:0]          diag_mm,
    output xp_class_e             cls,
    output logic [AW-1:0]         loc_row,
    output logic [AW-1:0]         loc_col
);
    logic [N-1:0]          row_live, col_live, diag_live;
    logic [N-1:0][N-1:0]   col_bits, diag_bits;
    logic [AW-1:0]         idx_r, idx_c;
    logic [N-1:0]          diag_want;
    logic                  single;

    for (genvar a = 0; a < N; a++) begin : g_live
        for (genvar r = 0; r < N; r++) begin : g_src
            assign col_bits[a][r]  = mem[r][a];
            assign diag_bits[a][r] = mem[r][(a - r + N) % N];
        end
        assign row_live[a]  = ^mem[a];
        assign col_live[a]  = ^col_bits[a];
        assign diag_live[a] = ^diag_bits[a];
    end

    // Compare live parity with the stored copies.
    always_comb begin
        row_mm  = row_live ^ row_p;
        col_mm  = col_live ^ col_p;
        diag_mm = diag_live ^ diag_p;
    end

    // Turn the row and column one-hot vectors into indices and the expected diagonal.
    always_comb begin
        idx_r = '0;
        idx_c = '0;
        for (int i = 0; i < N; i++) begin
            if (row_mm[i]) idx_r = AW'(i);
            if (col_mm[i]) idx_c = AW'(i);
        end
        diag_want = '0;
        for (int d = 0; d < N; d++)
            if (d == (int'(idx_r) + int'(idx_c)) % N) diag_want[d] = 1'b1;
    end

    // Classify the mismatch pattern and drive the location.
    always_comb begin
        single = ($countones(row_mm) == 1) && ($countones(col_mm) == 1)
                 && (diag_mm == diag_want);
        if (single)
            cls = XP_SINGLE;
        else if (|{row_mm, col_mm, diag_mm})
            cls = XP_MULTI;
        else
            cls = XP_CLEAN;
        loc_row = single ? idx_r : '0;
        loc_col = single ? idx_c : '0;
    end
endmodule

// File: rtl/xp_regfile_guard.sv
// Top: N x N register file guarded by row, column and diagonal parity.
// Wires the storage, the stored check bits and the classifier together.
// A write to the row holding a located upset uses the repaired old value.
// Assumes one write port, one read port, an injection port for upsets.
module xp_regfile_guard
    import xp_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [N-1:0]    wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [N-1:0]    rd_data,
    input  logic            corr_en,
    input  logic            flip_en,
    input  logic [AW-1:0]   flip_row,
    input  logic [AW-1:0]   flip_col,
    output logic            err,
    output logic            correctable,
    output logic            uncorrectable,
    output logic [N-1:0]    row_mm,
    output logic [N-1:0]    col_mm,
    output logic [N-1:0]    diag_mm,
    output logic [AW-1:0]   err_row,
    output logic [AW-1:0]   err_col
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0][N-1:0] mem_q;
    logic [N-1:0]        row_p, col_p, diag_p;
    logic [N-1:0]        old_fixed;
    xp_class_e           cls;
    logic [AW-1:0]       loc_row, loc_col;
    logic                fix_en;

    // Repair request qualified by a located single upset.
    always_comb fix_en = corr_en && (cls == XP_SINGLE);

    // Old value for the incremental update, with any located upset removed.
    always_comb begin
        old_fixed = mem_q[wr_addr];
        if (cls == XP_SINGLE && loc_row == wr_addr)
            old_fixed = old_fixed ^ (ONE << loc_col);
    end

    xp_store #(.N(N), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fix_en(fix_en), .fix_row(loc_row), .fix_col(loc_col),
        .flip_en(flip_en), .flip_row(flip_row), .flip_col(flip_col),
        .mem(mem_q)
    );

    xp_parity #(.N(N), .AW(AW)) u_parity (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .old_row(old_fixed),
        .row_p(row_p), .col_p(col_p), .diag_p(diag_p)
    );

    xp_locate #(.N(N), .AW(AW)) u_locate (
        .mem(mem_q), .row_p(row_p), .col_p(col_p), .diag_p(diag_p),
        .row_mm(row_mm), .col_mm(col_mm), .diag_mm(diag_mm),
        .cls(cls), .loc_row(loc_row), .loc_col(loc_col)
    );

    // Output drive: read port and flags.
    always_comb begin
        rd_data       = mem_q[rd_addr];
        err           = (cls != XP_CLEAN);
        correctable   = (cls == XP_SINGLE);
        uncorrectable = (cls == XP_MULTI);
        err_row       = loc_row;
        err_col       = loc_col;
    end

    // R3: without injection a clean file stays clean.
    assert_clean_stays_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flip_en && !err) |=> !err)
        else $error("mismatch appeared without an upset");

    // R4: an upset on a clean file is located at the injected bit.
    assert_single_located_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_en && !err) |=> (correctable && err_row == $past(flip_row)
                                && err_col == $past(flip_col)))
        else $error("single upset not located");

    // R6: a repair of a located upset clears the error.
    assert_fix_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && correctable && !flip_en) |=> !err)
        else $error("repair left a mismatch");

    // R7: repair request on an uncorrectable pattern leaves the contents alone.
    assert_uncorr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_en && uncorrectable && !wr_en && !flip_en) |=> $stable(mem_q))
        else $error("contents changed on uncorrectable repair");

    // R8: writing the faulty row leaves the check bits consistent.
    assert_write_repairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && correctable && wr_addr == err_row && !flip_en) |=> !err)
        else $error("write to faulty row left a mismatch");

    // R9: exactly one class flag while an error is present.
    assert_class_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $onehot({correctable, uncorrectable}))
        else $error("class flags inconsistent");
endmodule

// File: tb/tb_xp_regfile_guard.sv
// Cycle-by-cycle behavioural reference for the guarded register file.
// The model keeps the contents the check bits describe (golden) and the
// actual contents; mismatches are the parity of their difference.
module tb_xp_regfile_guard;
    localparam int N     = 8;
    localparam int AW    = 3;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          corr_en = 1'b0;
    logic          flip_en = 1'b0;
    logic [AW-1:0] flip_row = '0;
    logic [AW-1:0] flip_col = '0;
    logic          err, correctable, uncorrectable;
    logic [N-1:0]  row_mm, col_mm, diag_mm;
    logic [AW-1:0] err_row, err_col;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    logic [N-1:0] act_m [N];
    logic [N-1:0] gold_m [N];

    always #(CLK_P/2) clk = ~clk;

    xp_regfile_guard #(.N(N), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .corr_en(corr_en), .flip_en(flip_en), .flip_row(flip_row),
        .flip_col(flip_col), .err(err), .correctable(correctable),
        .uncorrectable(uncorrectable), .row_mm(row_mm), .col_mm(col_mm),
        .diag_mm(diag_mm), .err_row(err_row), .err_col(err_col)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected mismatch vectors and classification from the model.
    task automatic expect_state(output logic [N-1:0] rm, output logic [N-1:0] cm,
                                output logic [N-1:0] dm, output int cls,
                                output int lr, output int lc);
        logic [N-1:0] e;
        rm = '0; cm = '0; dm = '0;
        for (int r = 0; r < N; r++) begin
            e = act_m[r] ^ gold_m[r];
            for (int c = 0; c < N; c++) begin
                if (e[c]) begin
                    rm[r] = ~rm[r];
                    cm[c] = ~cm[c];
                    dm[(r + c) % N] = ~dm[(r + c) % N];
                end
            end
        end
        lr = 0; lc = 0;
        for (int i = 0; i < N; i++) begin
            if (rm[i]) lr = i;
            if (cm[i]) lc = i;
        end
        if ($countones(rm) == 1 && $countones(cm) == 1 && $countones(dm) == 1
            && dm[(lr + lc) % N])
            cls = 1;
        else if (rm != 0 || cm != 0 || dm != 0)
            cls = 2;
        else
            cls = 0;
        if (cls != 1) begin lr = 0; lc = 0; end
    endtask

    // One cycle: drive, compare all outputs, advance the model, clock.
    task automatic cyc(input bit we, input int wa, input int wd, input bit ce,
                       input bit fe, input int fr, input int fc, input int ra);
        logic [N-1:0] rm, cm, dm, oldu;
        int cls, lr, lc;
        wr_en = we; wr_addr = AW'(wa); wr_data = N'(wd);
        corr_en = ce; flip_en = fe; flip_row = AW'(fr); flip_col = AW'(fc);
        rd_addr = AW'(ra);
        #1;
        expect_state(rm, cm, dm, cls, lr, lc);
        chk("R2", "rd_data", int'(rd_data), int'(act_m[ra]));
        chk(cur_req, "row_mm", int'(row_mm), int'(rm));
        chk(cur_req, "col_mm", int'(col_mm), int'(cm));
        chk(cur_req, "diag_mm", int'(diag_mm), int'(dm));
        chk("R9", "err", int'(err), int'(cls != 0));
        chk(cur_req, "correctable", int'(correctable), int'(cls == 1));
        chk(cur_req, "uncorrectable", int'(uncorrectable), int'(cls == 2));
        chk("R10", "err_row", int'(err_row), lr);
        chk("R10", "err_col", int'(err_col), lc);
        // model next state
        if (we) begin
            oldu = act_m[wa];
            if (cls == 1 && lr == wa) oldu[lc] = ~oldu[lc];
            gold_m[wa] = gold_m[wa] ^ N'(wd) ^ oldu;
        end
        if (ce && cls == 1) act_m[lr][lc] = ~act_m[lr][lc];
        if (we) act_m[wa] = N'(wd);
        if (fe) act_m[fr][fc] = ~act_m[fr][fc];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int ra);
        cyc(0, 0, 0, 0, 0, 0, 0, ra);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 0; corr_en = 0; flip_en = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < N; r++) begin act_m[r] = '0; gold_m[r] = '0; end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: everything reads zero and no flag after reset
        cur_req = "R1";
        for (int r = 0; r < N; r++) begin
            rd_addr = AW'(r);
            #1;
            chk("R1", "rd_data after reset", int'(rd_data), 0);
        end
        chk("R1", "err after reset", int'(err), 0);
        chk("R1", "flags after reset", int'({correctable, uncorrectable}), 0);

        // R2 and R3: write patterns, read back, no mismatch
        cur_req = "R3";
        for (int r = 0; r < N; r++) cyc(1, r, (r * 37 + 5) & 8'hff, 0, 0, 0, 0, (r + 7) % N);
        cyc(1, 3, 8'hff, 0, 0, 0, 0, 3);
        cyc(1, 3, 8'h00, 0, 0, 0, 0, 3);
        cyc(1, 6, 8'ha5, 0, 0, 0, 0, 6);
        cyc(1, 6, 8'h5a, 0, 0, 0, 0, 6);
        for (int k = 0; k < 40; k++) cyc(1, (k * 5) % N, (k * 91 + 13) & 8'hff, 0, 0, 0, 0, k % N);
        idle(0);

        // R4 then R6: single upsets at corners and on a wrapping diagonal
        for (int k = 0; k < 5; k++) begin
            int fr, fc;
            fr = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 3 : (k == 3) ? 7 : 5;
            fc = (k == 0) ? 0 : (k == 1) ? 7 : (k == 2) ? 6 : (k == 3) ? 0 : 2;
            cur_req = "R4";
            cyc(0, 0, 0, 0, 1, fr, fc, fr);
            idle(fr);
            cur_req = "R6";
            cyc(0, 0, 0, 1, 0, 0, 0, fr);
            idle(fr);
        end

        // R6: repair and write to another row in the same cycle
        cur_req = "R6";
        cyc(0, 0, 0, 0, 1, 2, 4, 2);
        cyc(1, 5, 8'h3c, 1, 0, 0, 0, 5);
        idle(2);
        idle(5);

        // R8: write to the faulty row, without and with repair
        cur_req = "R8";
        cyc(0, 0, 0, 0, 1, 4, 1, 4);
        cyc(1, 4, 8'h81, 0, 0, 0, 0, 4);
        idle(4);
        cyc(0, 0, 0, 0, 1, 1, 6, 1);
        cyc(1, 1, 8'h7e, 1, 0, 0, 0, 1);
        idle(1);

        // R5 and R7: two upsets in one row, repair request ignored
        cur_req = "R5";
        cyc(0, 0, 0, 0, 1, 3, 1, 3);
        cyc(0, 0, 0, 0, 1, 3, 5, 3);
        cur_req = "R7";
        cyc(0, 0, 0, 1, 0, 0, 0, 3);
        idle(3);
        do_reset();

        // R5: two upsets on different rows, columns and diagonals; then a third
        cur_req = "R5";
        cyc(1, 0, 8'h12, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 2, 4, 2);
        cur_req = "R7";
        cyc(0, 0, 0, 1, 0, 0, 0, 2);
        cur_req = "R5";
        cyc(0, 0, 0, 0, 1, 6, 6, 6);
        idle(6);
        do_reset();

        // R3: clean after second reset, more writes
        cur_req = "R3";
        for (int k = 0; k < 16; k++) cyc(1, k % N, (k * 29 + 1) & 8'hff, k % 3 == 0, 0, 0, 0, (k + 1) % N);
        idle(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule